// File: doc/BRIEF.md
# Prescaled 16-bit timer peripheral

This block is a byte-addressed 16-bit up-counter for a small microcontroller. Software configures it through four byte registers: a control register, the low and high bytes of the count, and an interrupt register that holds the local interrupt enable and the overflow flag. The count advances on a selected tick, after an optional power-of-two prescaler. The tick is either the core's instruction-rate strobe or rising edges on an external pin, which lets the block act as an event counter. The external pin can pass through a two-stage synchroniser, or it can be edge-detected straight from the pin for lower latency.

Each wrap of the count from all ones to zero sets a sticky overflow flag. An interrupt request is raised when that flag, the local enable and a chip-level enable input are all set. The two count bytes are plain, separately accessed registers with no snapshot latch. Software that needs a coherent 16-bit value stops the timer first.

Register map (bus_addr_i): 0 control, 1 count low byte, 2 count high byte, 3 interrupt register. Control bits: bit 0 run, bit 1 external source, bit 2 bypass the synchroniser, bits 5:4 prescale select. Bits 3, 7 and 6 read as zero. Interrupt register bits: bit 0 local enable, bit 1 overflow flag.

Top module: `ovf_timer16`

## Requirements
- R1: After reset the control register, both count bytes and the interrupt register read 0x00, and irq_o is 0.
- R2: While the run bit (control bit 0) is 0, the count holds its value whatever the tick inputs do.
- R3: With run set, internal source (control bit 1 = 0) and prescale select 00, the count rises by exactly one for each clock cycle in which inst_tick_i is 1.
- R4: Prescale select (control bits 5:4) 00, 01, 10 and 11 give one count step per 1, 2, 4 and 8 selected ticks.
- R5: With control bit 1 = 1, the count steps on rising edges of ext_clk_i only, and inst_tick_i is ignored.
- R6: With control bit 2 = 0, an external rising edge reaches the count three clock edges after the pin rises. With control bit 2 = 1, it reaches the count on the first edge.
- R7: A write to count byte 1 (low) or 2 (high) loads that byte on the write edge and leaves the other byte unchanged. It also restarts the prescaler, so the next step takes a full prescale period.
- R8: Each wrap from 0xFFFF to 0x0000 sets the overflow flag (interrupt register bit 1) on the same edge.
- R9: The flag stays set until software writes bit 1 of the interrupt register as 0. A wrap on the same edge as such a write leaves the flag set.
- R10: irq_o is a register that is 1 exactly one cycle after the flag, the local enable (interrupt register bit 0) and gie_i are all 1.
- R11: With prescale 11 and a start value S, the flag sets after 8 x (65536 - S) ticks, which is 524288 ticks from zero.
- R12: Each count byte reads back its current value with no latch. A carry between a low-byte read and a high-byte read shows in the high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| inst_tick_i | input | 1 | Instruction-rate tick strobe |
| ext_clk_i | input | 1 | External clock or event input |
| gie_i | input | 1 | Chip-level interrupt enable |
| bus_addr_i | input | 2 | Register address |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_data_o | output | 8 | Read data, valid the cycle after rd_en_i |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions check on every cycle that the count moves by at most one step without a write, that a stopped and unwritten count stays stable, and that a wrap lands on zero and sets the flag. They also check that the flag stays set until a clearing write, that irq_o never rises without the flag and both enables, that prescaled steps are never back to back, and that a synchronised external edge is a one-cycle pulse. Only the bench scenarios can show the actual divide ratios, the different latencies of the synchronised and bypassed external paths, the prescaler restart on a count write, the overflow period, and the non-atomic byte reads.

// File: rtl/ovf_timer16_pkg.sv
package ovf_timer16_pkg;

  localparam int BYTE_W    = 8;
  localparam int PRE_SEL_W = 2;
  localparam int SYNC_LEN  = 2;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_CNT_LO = 2'd1,
    REG_CNT_HI = 2'd2,
    REG_IRQ    = 2'd3
  } reg_addr_e;

  localparam int CTL_RUN    = 0;
  localparam int CTL_EXT    = 1;
  localparam int CTL_NOSYNC = 2;
  localparam int CTL_PRE_LO = 4;

  localparam int IRQ_IE   = 0;
  localparam int IRQ_FLAG = 1;

  typedef struct packed {
    logic                 run;
    logic                 ext;
    logic                 nosync;
    logic [PRE_SEL_W-1:0] pre_sel;
  } ctrl_t;

endpackage

// File: rtl/ovf_timer16_extsync.sv
module ovf_timer16_extsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic bypass_i,
  output logic edge_o
);

  logic [STAGES-1:0] sh_q;
  logic              prev_q;
  logic              edge_sync;
  logic              edge_raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= (sh_q << 1) | STAGES'(pin_i);
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign edge_sync = sh_q[STAGES-1] & ~prev_q;
  assign edge_raw  = pin_i & ~sh_q[0];
  assign edge_o    = bypass_i ? edge_raw : edge_sync;

  // R5: a synchronised edge is a single-cycle pulse
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (!bypass_i && edge_o) |=> (bypass_i || !edge_o));

endmodule

// File: rtl/ovf_timer16_prescale.sv
module ovf_timer16_prescale #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             inc_o
);

  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] pre_q;
  logic [DIV_W-1:0] limit;
  logic             at_end;

  always_comb begin
    limit = '0;
    for (int i = 0; i < DIV_W; i++) begin
      if (i < int'(sel_i)) limit[i] = 1'b1;
    end
  end

  assign at_end = (pre_q >= limit);
  assign inc_o  = en_i & tick_i & at_end;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      pre_q <= '0;
    end else if (en_i && tick_i) begin
      pre_q <= at_end ? '0 : pre_q + 1'b1;
    end
  end

  // R4: with any divide above one, steps never come on consecutive cycles
  a_r4_spacing: assert property (@(posedge clk) disable iff (rst)
    (inc_o && sel_i != '0) |=> (sel_i == '0 || !inc_o));

endmodule

// File: rtl/ovf_timer16_count.sv
module ovf_timer16_count #(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inc_i,
  input  logic            wr_lo_i,
  input  logic            wr_hi_i,
  input  logic [BW-1:0]   wdata_i,
  output logic [2*BW-1:0] cnt_o,
  output logic            wrap_o
);

  localparam int CW = 2 * BW;

  logic [CW-1:0] cnt_q;
  logic          wr_any;

  assign wr_any = wr_lo_i | wr_hi_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wr_any) begin
      if (wr_lo_i) cnt_q[BW-1:0]  <= wdata_i;
      if (wr_hi_i) cnt_q[CW-1:BW] <= wdata_i;
    end else if (inc_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign wrap_o = inc_i & ~wr_any & (&cnt_q);
  assign cnt_o  = cnt_q;

  // R8: a wrap leaves the count at zero
  a_r8_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> (cnt_q == '0));

  // R3: without a write the count moves by at most one step
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    !wr_any |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

  // R7: a low-byte write leaves the high byte alone
  a_r7_keep_hi: assert property (@(posedge clk) disable iff (rst)
    (wr_lo_i && !wr_hi_i) |=> (cnt_q[CW-1:BW] == $past(cnt_q[CW-1:BW])));

endmodule

// File: rtl/ovf_timer16.sv
module ovf_timer16
  import ovf_timer16_pkg::*;
#(
  parameter int BW    = BYTE_W,
  parameter int SEL_W = PRE_SEL_W,
  parameter int SYNC  = SYNC_LEN
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inst_tick_i,
  input  logic          ext_clk_i,
  input  logic          gie_i,
  input  logic [1:0]    bus_addr_i,
  input  logic          wr_en_i,
  input  logic [BW-1:0] wr_data_i,
  input  logic          rd_en_i,
  output logic [BW-1:0] rd_data_o,
  output logic          irq_o
);

  localparam int CW = 2 * BW;

  ctrl_t         ctrl_q;
  logic          ie_q;
  logic          flag_q;
  logic          wr_ctrl, wr_lo, wr_hi, wr_irq;
  logic          ext_edge;
  logic          sel_tick;
  logic          inc;
  logic          wrap;
  logic [CW-1:0] cnt;
  logic [BW-1:0] ctrl_rd;
  logic [BW-1:0] irq_rd;

  assign wr_ctrl = wr_en_i && (bus_addr_i == REG_CTRL);
  assign wr_lo   = wr_en_i && (bus_addr_i == REG_CNT_LO);
  assign wr_hi   = wr_en_i && (bus_addr_i == REG_CNT_HI);
  assign wr_irq  = wr_en_i && (bus_addr_i == REG_IRQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.run     <= wr_data_i[CTL_RUN];
      ctrl_q.ext     <= wr_data_i[CTL_EXT];
      ctrl_q.nosync  <= wr_data_i[CTL_NOSYNC];
      ctrl_q.pre_sel <= wr_data_i[CTL_PRE_LO +: SEL_W];
    end
  end

  ovf_timer16_extsync #(.STAGES(SYNC)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .pin_i    (ext_clk_i),
    .bypass_i (ctrl_q.nosync),
    .edge_o   (ext_edge)
  );

  assign sel_tick = ctrl_q.ext ? ext_edge : inst_tick_i;

  ovf_timer16_prescale #(.SEL_W(SEL_W)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .en_i   (ctrl_q.run),
    .tick_i (sel_tick),
    .clr_i  (wr_lo | wr_hi),
    .sel_i  (ctrl_q.pre_sel),
    .inc_o  (inc)
  );

  ovf_timer16_count #(.BW(BW)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .inc_i   (inc),
    .wr_lo_i (wr_lo),
    .wr_hi_i (wr_hi),
    .wdata_i (wr_data_i),
    .cnt_o   (cnt),
    .wrap_o  (wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      if (wr_irq) ie_q <= wr_data_i[IRQ_IE];
      if (wrap)        flag_q <= 1'b1;
      else if (wr_irq) flag_q <= wr_data_i[IRQ_FLAG];
      irq_o <= flag_q & ie_q & gie_i;
    end
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CTL_RUN]    = ctrl_q.run;
    ctrl_rd[CTL_EXT]    = ctrl_q.ext;
    ctrl_rd[CTL_NOSYNC] = ctrl_q.nosync;
    ctrl_rd[CTL_PRE_LO +: SEL_W] = ctrl_q.pre_sel;
    irq_rd = '0;
    irq_rd[IRQ_IE]   = ie_q;
    irq_rd[IRQ_FLAG] = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o <= '0;
    end else if (rd_en_i) begin
      case (bus_addr_i)
        REG_CTRL:   rd_data_o <= ctrl_rd;
        REG_CNT_LO: rd_data_o <= cnt[BW-1:0];
        REG_CNT_HI: rd_data_o <= cnt[CW-1:BW];
        default:    rd_data_o <= irq_rd;
      endcase
    end
  end

  // R2: stopped and unwritten, the count is stable
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.run && !wr_lo && !wr_hi) |=> $stable(cnt));

  // R8: a wrap sets the flag
  a_r8_flag_set: assert property (@(posedge clk) disable iff (rst)
    wrap |=> flag_q);

  // R9: the flag only drops through a register write
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !wr_irq) |=> flag_q);

  // R10: a request needs the flag and both enables one cycle earlier
  a_r10_irq_flag: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(flag_q));
  a_r10_irq_enables: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ($past(ie_q) && $past(gie_i)));

endmodule

// File: tb/ovf_timer16_tb_top.sv
module ovf_timer16_tb_top;
  import ovf_timer16_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inst_tick = 1'b0;
  logic       ext_clk = 1'b0;
  logic       gie = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       irq;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;
  logic pend    = 1'b0;

  logic [7:0] q_exp[$];
  string      q_tag[$];

  always #5 clk = ~clk;

  ovf_timer16 dut_i (
    .clk         (clk),
    .rst         (rst),
    .inst_tick_i (inst_tick),
    .ext_clk_i   (ext_clk),
    .gie_i       (gie),
    .bus_addr_i  (bus_addr),
    .wr_en_i     (wr_en),
    .wr_data_i   (wr_data),
    .rd_en_i     (rd_en),
    .rd_data_o   (rd_data),
    .irq_o       (irq)
  );

  // Monitor: compares read data against the scoreboard queue
  always @(posedge clk) pend <= rd_en;

  always @(negedge clk) begin
    if (pend && q_exp.size() > 0) begin
      logic [7:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      n_checks++;
      if (rd_data !== e) begin
        n_fails++;
        $display("FAIL %s: actual=0x%02h expected=0x%02h", t, rd_data, e);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a;
    wr_data  = d;
    wr_en    = 1'b1;
    @(negedge clk);
    wr_en    = 1'b0;
  endtask

  task automatic rd_exp(input logic [1:0] a, input logic [7:0] e, input string t);
    q_exp.push_back(e);
    q_tag.push_back(t);
    bus_addr = a;
    rd_en    = 1'b1;
    @(negedge clk);
    rd_en    = 1'b0;
  endtask

  task automatic ticks(input int n);
    inst_tick = 1'b1;
    repeat (n) @(negedge clk);
    inst_tick = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_checks++;
    if (irq !== e) begin
      n_fails++;
      $display("FAIL %s: actual irq=%0b expected=%0b", t, irq, e);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);

    // R1 reset values
    rd_exp(REG_CTRL,   8'h00, "R1 ctrl");
    rd_exp(REG_CNT_LO, 8'h00, "R1 cnt lo");
    rd_exp(REG_CNT_HI, 8'h00, "R1 cnt hi");
    rd_exp(REG_IRQ,    8'h00, "R1 irq reg");
    chk_irq(1'b0, "R1 irq_o");

    // R2 stopped timer ignores ticks
    ticks(5);
    rd_exp(REG_CNT_LO, 8'h00, "R2 hold while off");

    // R3 divide by one
    wr(REG_CTRL, 8'h01);
    wr(REG_CNT_LO, 8'h00);
    ticks(7);
    rd_exp(REG_CNT_LO, 8'h07, "R3 div1 count");
    rd_exp(REG_CTRL,   8'h01, "R3 ctrl readback");

    // R4 other ratios: 20 ticks give 10, 5, 2 steps
    for (int s = 1; s < 4; s++) begin
      wr(REG_CTRL, 8'((s << 4) | 1));
      wr(REG_CNT_HI, 8'h00);
      wr(REG_CNT_LO, 8'h00);
      ticks(20);
      rd_exp(REG_CNT_LO, 8'(20 >> s), "R4 prescale ratio");
    end

    // R2 stop after running
    wr(REG_CTRL, 8'h30);
    ticks(10);
    rd_exp(REG_CNT_LO, 8'h02, "R2 hold after stop");

    // R7 byte loads and prescaler restart
    wr(REG_CNT_HI, 8'h12);
    rd_exp(REG_CNT_HI, 8'h12, "R7 hi load");
    rd_exp(REG_CNT_LO, 8'h02, "R7 lo untouched");
    wr(REG_CTRL, 8'h31);
    wr(REG_CNT_LO, 8'h00);
    ticks(5);
    wr(REG_CNT_LO, 8'h40);
    ticks(7);
    rd_exp(REG_CNT_LO, 8'h40, "R7 prescaler restarted");
    ticks(1);
    rd_exp(REG_CNT_LO, 8'h41, "R7 step after full period");
    rd_exp(REG_CNT_HI, 8'h12, "R7 hi untouched");

    // R5 synchronised external events, internal tick ignored
    wr(REG_CTRL, 8'h03);
    wr(REG_CNT_HI, 8'h00);
    wr(REG_CNT_LO, 8'h00);
    inst_tick = 1'b1;
    for (int k = 0; k < 3; k++) begin
      ext_clk = 1'b1; idle(3);
      ext_clk = 1'b0; idle(3);
    end
    inst_tick = 1'b0;
    idle(4);
    rd_exp(REG_CNT_LO, 8'h03, "R5 external event count");

    // R6 synchronised latency: read on edge 2 sees old value
    wr(REG_CNT_LO, 8'h00);
    ext_clk = 1'b1;
    @(negedge clk);
    rd_exp(REG_CNT_LO, 8'h00, "R6 sync path not yet counted");
    idle(2);
    rd_exp(REG_CNT_LO, 8'h01, "R6 sync path counted");
    ext_clk = 1'b0;
    idle(4);

    // R6 bypassed path counts on the first edge
    wr(REG_CTRL, 8'h07);
    wr(REG_CNT_LO, 8'h00);
    ext_clk = 1'b1;
    @(negedge clk);
    rd_exp(REG_CNT_LO, 8'h01, "R6 bypass path counted early");
    ext_clk = 1'b0;
    idle(4);

    // R8 R10 R11 overflow from 0xFF00 at divide 8: 2048 ticks
    wr(REG_CTRL, 8'h31);
    gie = 1'b1;
    wr(REG_IRQ, 8'h01);
    wr(REG_CNT_HI, 8'hFF);
    wr(REG_CNT_LO, 8'h00);
    ticks(2047);
    rd_exp(REG_CNT_LO, 8'hFF, "R11 one tick short lo");
    rd_exp(REG_CNT_HI, 8'hFF, "R11 one tick short hi");
    rd_exp(REG_IRQ,    8'h01, "R11 no flag yet");
    chk_irq(1'b0, "R10 no request before wrap");
    ticks(1);
    idle(1);
    chk_irq(1'b1, "R10 request after wrap");
    rd_exp(REG_CNT_LO, 8'h00, "R8 wrap lo");
    rd_exp(REG_CNT_HI, 8'h00, "R8 wrap hi");
    rd_exp(REG_IRQ,    8'h03, "R8 flag set");

    // R9 sticky flag
    ticks(100);
    rd_exp(REG_IRQ,    8'h03, "R9 flag sticky");
    rd_exp(REG_CNT_LO, 8'h0C, "R11 count continues");

    // R10 gating
    gie = 1'b0;
    idle(2);
    chk_irq(1'b0, "R10 chip enable low");
    gie = 1'b1;
    wr(REG_IRQ, 8'h02);
    idle(1);
    chk_irq(1'b0, "R10 local enable low");
    rd_exp(REG_IRQ, 8'h02, "R9 flag kept, enable cleared");
    wr(REG_IRQ, 8'h03);
    idle(1);
    chk_irq(1'b1, "R10 both enables");
    wr(REG_IRQ, 8'h01);
    idle(1);
    chk_irq(1'b0, "R9 clear drops request");
    rd_exp(REG_IRQ, 8'h01, "R9 flag cleared by write");

    // R9 wrap beats a clearing write on the same edge
    wr(REG_CTRL, 8'h01);
    wr(REG_CNT_HI, 8'hFF);
    wr(REG_CNT_LO, 8'hFF);
    inst_tick = 1'b1;
    bus_addr  = REG_IRQ;
    wr_data   = 8'h01;
    wr_en     = 1'b1;
    @(negedge clk);
    inst_tick = 1'b0;
    wr_en     = 1'b0;
    rd_exp(REG_IRQ,    8'h03, "R9 wrap wins over clear");
    rd_exp(REG_CNT_LO, 8'h00, "R8 wrap with clear write");
    wr(REG_IRQ, 8'h01);

    // R12 non-atomic byte reads
    wr(REG_CNT_HI, 8'h00);
    wr(REG_CNT_LO, 8'hFF);
    rd_exp(REG_CNT_LO, 8'hFF, "R12 low read");
    ticks(1);
    rd_exp(REG_CNT_HI, 8'h01, "R12 carry visible in high read");

    idle(4);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule